// File: doc/BRIEF.md
# PS/2 Device-Side Command Receiver

This block is the device end of a PS/2 link, and it receives command bytes sent by the host. The clock and data lines are open-drain. The block reads each line through an input pin and pulls it low through an output-enable pin.

While idle, the block looks at both lines once per poll interval. A request to send is the host holding data low while clock is released. When the block sees one, it drives eleven clock pulses of its own:

- Pulses one to eight carry the data bits, least significant first.
- Pulse nine carries the parity bit.
- Pulse ten carries the stop bit.
- Pulse eleven carries the acknowledge, during which the block pulls data low.

Each bit is sampled at the end of the phase in which clock is released. The host changes data only while clock is low.

Once the acknowledge is done, the block releases data and checks that the host has let go of the line. It reports the byte with a one-cycle valid pulse, or with a one-cycle error pulse if the frame is bad. If the host keeps data low, the block goes on issuing clock pulses until data is released and then reports an error.

The host can hold clock low while the block has released it. A short hold stretches the current bit. A hold of the inhibit length before the acknowledge abandons the reception without a result. The bit rate, poll interval and inhibit time are derived from the system clock frequency.

Top module: `ps2_cmd_rx`

## Requirements
- R1: After reset neither line is driven, byte_valid and byte_err are 0 and rx_byte is 0.
- R2: The block starts clock pulses no later than POLL_US microseconds (plus 4 cycles of synchronisation) after the host has released clock while holding data low.
- R3: Every clock pulse the block drives holds the clock line low for exactly CLK_HZ/(2*PS2_HZ) system cycles.
- R4: Pulses one to eight carry the data bits, least significant bit first, and the byte is presented on rx_byte. Each bit is taken from the data line near the end of the phase in which clock is released.
- R5: Data is pulled low starting at the falling edge of the eleventh clock pulse and held through that pulse. It is released only while the clock line is not being driven.
- R6: If the ninth bit makes the count of ones across data and parity odd, and the tenth bit is 1, byte_valid pulses for one cycle.
- R7: If the parity does not make that count odd, byte_err pulses instead of byte_valid.
- R8: If the stop bit is 0, or data is still low after the acknowledge, byte_err pulses. While data stays low, extra clock pulses continue and no result is given until the host releases data.
- R9: A host hold of the clock line lasting INHIBIT_US or longer, during a released phase before the acknowledge pulse, ends the reception. No result is produced and no further pulses are issued until a new request to send.
- R10: A host hold of the clock line shorter than INHIBIT_US only stretches the released phase, and the byte is still received correctly.
- R11: byte_valid and byte_err are never high together. Each is high for only one cycle at a time. rx_byte changes only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Level seen on the PS/2 clock line |
| ps2_data_i | input | 1 | Level seen on the PS/2 data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_data_oe | output | 1 | 1 pulls the data line low |
| rx_byte | output | 8 | Last received byte |
| byte_valid | output | 1 | One-cycle pulse: rx_byte holds a good byte |
| byte_err | output | 1 | One-cycle pulse: frame error or stuck data line |

## Verification
The clock enable falls exactly CLK_HZ/(2*PS2_HZ) cycles after it rises, and the bench measures the length of every low phase on falling system-clock edges. The acknowledge drive is checked one time unit after the eleventh pulse's clock enable falls. The result pulse comes three cycles after the block releases data following the acknowledge, or at the end of the first extra pulse whose released phase sees data high.

Expected results are pushed into a queue, and for a stuck line this happens only at the moment the host model releases data. The monitor pops one entry for each result pulse it sees on a falling edge, so a result that comes too early, or one after an abort, finds the queue empty and is reported.

// File: rtl/ps2_cmd_rx.sv
`timescale 1ns/1ps
module ps2_cmd_rx #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int PS2_HZ     = 12_500,
  parameter int POLL_US    = 5_000,
  parameter int INHIBIT_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       ps2_clk_oe,
  output logic       ps2_data_oe,
  output logic [7:0] rx_byte,
  output logic       byte_valid,
  output logic       byte_err
);
  localparam int HALF = CLK_HZ / (2 * PS2_HZ);
  localparam int POLL = (CLK_HZ / 1_000_000) * POLL_US;
  localparam int INH  = (CLK_HZ / 1_000_000) * INHIBIT_US;
  localparam int TW   = $clog2(POLL + HALF + 1);
  localparam int IW   = $clog2(INH + 1);

  typedef enum logic [1:0] {IDLE, LOW, HIGH, SETTLE} st_t;

  st_t         st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] inh;
  logic [3:0]  pulse;
  logic [9:0]  sh;
  logic        stuck;
  logic [1:0]  cs, ds, oe_hist;

  wire clk_s     = cs[1];
  wire data_s    = ds[1];
  wire host_low  = ~clk_s & ~oe_hist[1];
  wire frame_ok  = (^sh[8:0]) & sh[9];
  wire half_done = (tmr == TW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs      <= 2'b11;
      ds      <= 2'b11;
      oe_hist <= 2'b00;
    end else begin
      cs      <= {cs[0], ps2_clk_i};
      ds      <= {ds[0], ps2_data_i};
      oe_hist <= {oe_hist[0], ps2_clk_oe};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      tmr         <= '0;
      inh         <= '0;
      pulse       <= '0;
      sh          <= '0;
      stuck       <= 1'b0;
      ps2_clk_oe  <= 1'b0;
      ps2_data_oe <= 1'b0;
      rx_byte     <= '0;
      byte_valid  <= 1'b0;
      byte_err    <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      byte_err   <= 1'b0;
      case (st)
        IDLE: begin
          ps2_clk_oe  <= 1'b0;
          ps2_data_oe <= 1'b0;
          if (tmr == TW'(POLL - 1)) begin
            tmr <= '0;
            if (clk_s && !data_s) begin
              st         <= LOW;
              ps2_clk_oe <= 1'b1;
              pulse      <= '0;
              stuck      <= 1'b0;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        LOW: begin
          if (half_done) begin
            tmr        <= '0;
            inh        <= '0;
            ps2_clk_oe <= 1'b0;
            st         <= HIGH;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        HIGH: begin
          if (host_low) begin
            if (inh != IW'(INH - 1)) begin
              inh <= inh + 1'b1;
            end else if (!stuck && pulse != 4'd10) begin
              st          <= IDLE;
              tmr         <= '0;
              ps2_data_oe <= 1'b0;
            end
          end else if (half_done) begin
            tmr <= '0;
            if (stuck) begin
              if (data_s) begin
                byte_err <= 1'b1;
                rx_byte  <= sh[7:0];
                st       <= IDLE;
              end else begin
                ps2_clk_oe <= 1'b1;
                st         <= LOW;
              end
            end else if (pulse != 4'd10) begin
              sh         <= {data_s, sh[9:1]};
              pulse      <= pulse + 1'b1;
              ps2_clk_oe <= 1'b1;
              st         <= LOW;
              if (pulse == 4'd9) ps2_data_oe <= 1'b1;
            end else begin
              ps2_data_oe <= 1'b0;
              st          <= SETTLE;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SETTLE: begin
          if (tmr == TW'(2)) begin
            tmr <= '0;
            if (data_s) begin
              rx_byte    <= sh[7:0];
              byte_valid <= frame_ok;
              byte_err   <= ~frame_ok;
              st         <= IDLE;
            end else begin
              stuck      <= 1'b1;
              ps2_clk_oe <= 1'b1;
              st         <= LOW;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module ps2_cmd_rx_chk #(
  parameter int CLK_HZ = 50_000_000,
  parameter int PS2_HZ = 12_500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ps2_clk_oe,
  input logic       ps2_data_oe,
  input logic [7:0] rx_byte,
  input logic       byte_valid,
  input logic       byte_err
);
  localparam int HALF = CLK_HZ / (2 * PS2_HZ);
  int low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_len <= 0;
    else if (ps2_clk_oe) low_len <= low_len + 1;
    else                 low_len <= 0;
  end

  // R3
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> low_len == HALF);

  // R5
  ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_data_oe) |-> $rose(ps2_clk_oe));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_data_oe) |-> !ps2_clk_oe);

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && byte_err));

  // R11
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || byte_err) |=> !(byte_valid || byte_err));

  // R11
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_valid && !byte_err) |-> $stable(rx_byte));

  // R6
  result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || byte_err) |-> (!ps2_clk_oe && !ps2_data_oe));
endmodule

bind ps2_cmd_rx ps2_cmd_rx_chk #(.CLK_HZ(CLK_HZ), .PS2_HZ(PS2_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe),
  .rx_byte(rx_byte), .byte_valid(byte_valid), .byte_err(byte_err)
);

// File: tb/ps2_cmd_rx_bench.sv
`timescale 1ns/1ps
module ps2_cmd_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 40;
  localparam int POLL = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_clk_low = 1'b0;
  logic host_data_low = 1'b0;
  logic ps2_clk_oe, ps2_data_oe, byte_valid, byte_err;
  logic [7:0] rx_byte;
  wire ps2_clk  = ~(ps2_clk_oe | host_clk_low);
  wire ps2_data = ~(ps2_data_oe | host_data_low);

  int checks = 0;
  int fails = 0;
  int low_cnt = 0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_cmd_rx #(.CLK_HZ(1_000_000), .PS2_HZ(12_500), .POLL_US(200), .INHIBIT_US(100)) u_ps2_cmd_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_data_i(ps2_data),
    .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe), .rx_byte(rx_byte),
    .byte_valid(byte_valid), .byte_err(byte_err)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R3: low phase length of each driven pulse
  always @(negedge clk) begin
    if (ps2_clk_oe) low_cnt = low_cnt + 1;
    else if (low_cnt != 0) begin
      check(low_cnt == HALF, "R3", "clock low cycles", low_cnt, HALF);
      low_cnt = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    logic [8:0] e;
    if (rst_n && (byte_valid || byte_err)) begin
      check(!(byte_valid && byte_err), "R11", "valid and err together", {byte_valid, byte_err}, 2);
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected result", {byte_err, rx_byte}, 0);
      end else begin
        e = exp_q.pop_front();
        if (e[8]) check(byte_err == 1'b1, "R7", "error flag", {byte_err, rx_byte}, e);
        else begin
          check(byte_valid == 1'b1, "R6", "valid flag", {byte_err, rx_byte}, e);
          check(rx_byte == e[7:0], "R4", "received byte", rx_byte, e[7:0]);
        end
      end
    end
  end

  task automatic request_to_send();
    int n;
    host_clk_low = 1'b1;
    repeat (120) @(posedge clk);
    host_data_low = 1'b1;
    repeat (5) @(posedge clk);
    host_clk_low = 1'b0;
    n = 0;
    while (!ps2_clk_oe) begin
      @(posedge clk); #1;
      n++;
    end
    check(n <= POLL + 4, "R2", "cycles to first pulse", n, POLL + 4);
  endtask

  task automatic host_send(input logic [7:0] b, input logic par_flip, input logic stop_v,
                           input int hold, input logic stall);
    logic [9:0] f;
    f = {stop_v, (~^b) ^ par_flip, b};
    if (hold == 0) exp_q.push_back({(par_flip | ~stop_v), b});
    request_to_send();
    host_data_low = ~f[0];
    for (int i = 1; i < 10; i++) begin
      if (stall && i == 5) begin
        @(negedge ps2_clk_oe);
        repeat (3) @(posedge clk);
        host_clk_low = 1'b1;
        repeat (30) @(posedge clk);
        host_clk_low = 1'b0;
      end
      @(posedge ps2_clk_oe); #1;
      host_data_low = ~f[i];
    end
    @(posedge ps2_clk_oe); #1;
    if (hold == 0) host_data_low = 1'b0;
    @(negedge ps2_clk_oe); #1;
    check(ps2_data_oe == 1'b1 && ps2_data == 1'b0, "R5", "acknowledge drive", ps2_data_oe, 1);
    if (hold > 0) begin
      for (int k = 0; k < hold; k++) begin
        @(posedge ps2_clk_oe); #1;
      end
      exp_q.push_back({1'b1, b}); // R8: no result may precede this release
      host_data_low = 1'b0;
    end
    while (exp_q.size() != 0) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  task automatic host_abort();
    bit quiet;
    request_to_send();
    host_data_low = 1'b0;
    for (int i = 1; i < 3; i++) begin
      @(posedge ps2_clk_oe); #1;
      host_data_low = 1'b1;
    end
    @(negedge ps2_clk_oe);
    repeat (3) @(posedge clk);
    host_clk_low = 1'b1;
    host_data_low = 1'b0;
    repeat (130) @(posedge clk);
    host_clk_low = 1'b0;
    quiet = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (ps2_clk_oe || ps2_data_oe) quiet = 1'b0;
    end
    check(quiet, "R9", "lines idle after abort", !quiet, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired (R2/R8 progress): actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!ps2_clk_oe && !ps2_data_oe, "R1", "lines driven after reset", {ps2_clk_oe, ps2_data_oe}, 0);
    check(!byte_valid && !byte_err, "R1", "flags after reset", {byte_valid, byte_err}, 0);
    check(rx_byte == 8'h00, "R1", "byte after reset", rx_byte, 0);
    host_send(8'hA5, 1'b0, 1'b1, 0, 1'b0); // R6
    host_send(8'h01, 1'b0, 1'b1, 0, 1'b0); // R4 lsb first
    host_send(8'h80, 1'b0, 1'b1, 0, 1'b0); // R4
    host_send(8'h3C, 1'b1, 1'b1, 0, 1'b0); // R7 parity
    host_send(8'h77, 1'b0, 1'b0, 0, 1'b0); // R8 stop bit 0
    host_send(8'h42, 1'b0, 1'b0, 3, 1'b0); // R8 stuck data
    host_send(8'h5A, 1'b0, 1'b1, 0, 1'b1); // R10 short hold
    host_abort();                          // R9
    host_send(8'hC3, 1'b0, 1'b1, 0, 1'b0); // R9 recovery
    host_send(8'hFF, 1'b0, 1'b1, 0, 1'b0);
    check(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule